// File: doc/BRIEF.md
# Rate 8/9 Run-Length-Limited Write Encoder

This block sits on the write path of a disk channel. It takes bytes from the controller, one byte per handshake and aligned to the write clock, and turns each byte into a 9-bit code word. It then shifts the code word out one bit per clock, most significant bit first. The code words are chosen so that the joined bit stream never holds more than four zeros in a row. The same limit of four zeros also holds in the two interleaved streams made of every other bit.

The serialiser runs on every clock. It asks for a new byte only while it sends the last bit of the current word. If the controller has no byte at that moment, the next word is a filler of all ones and a flag marks that word as an underrun. An internal monitor follows the outgoing stream and raises an error output if any zero run goes over its limit. The test bench uses this output as a diagnostic.

Top module: `rll89_encoder`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `code_bit`=1, `word_start`=1, `in_ready`=0, `underrun`=0 and `run_err`=0. Reset also cancels a word that is part-way out.
- R2: Byte value n (0..255) is encoded as the n-th smallest 9-bit value, counting from 0, among the words that meet all of these rules. Rule 1: at most 2 leading zeros and at most 2 trailing zeros. Rule 2: no zero run longer than 4. Rule 3: in the bit positions 8,6,4,2,0 and in the bit positions 7,5,3,1, each taken on its own, at most 2 leading zeros, at most 2 trailing zeros and no zero run longer than 4. By this rule byte 0 encodes to 9'h049.
- R3: Each word takes exactly 9 clocks and is sent bit 8 first, one bit per clock, on `code_bit`. `word_start` is high during the clock that carries bit 8 and low during the other 8 clocks.
- R4: `in_ready` is high only during the last (9th) bit of a word. A byte with `in_valid` high in that clock becomes the next word. Words follow each other with no gap.
- R5: If `in_valid` is low while `in_ready` is high, the next word is 9'h1FF and `underrun` is high for all 9 of its clocks. For a word that carries data, `underrun` is low.
- R6: For any sequence of input bytes and gaps, `code_bit` never shows more than 4 zeros in a row, and this holds across word boundaries.
- R7: Take the output bits at even stream positions counted since reset, and separately those at odd positions. Neither group ever shows more than 4 zeros in a row.
- R8: `run_err` goes high one clock after the output shows a run of zeros that breaks the limit of R6 or R7. Because the encoder meets both limits, it stays low.
- R9: Outside the `in_ready` clock, `in_valid` and `in_data` have no effect. In particular, data that changes while the block waits is not captured; only the value present in the ready clock is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, one code bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte to encode |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Byte taken at this clock edge if valid |
| code_bit | output | 1 | Serial code bit, MSB of each word first |
| word_start | output | 1 | Marks the first bit of each code word |
| underrun | output | 1 | Current word is filler, no byte was offered |
| run_err | output | 1 | Zero-run limit exceeded (diagnostic) |

## Verification
The assertions check these on every clock:
- the 9-clock word rhythm and where `word_start` falls within it;
- that `in_ready` is always followed by the start of a word;
- that `underrun` follows the handshake and does not change inside a word;
- that the plain zero run on `code_bit` stays within four;
- that `run_err` stays low.

Only the bench scenarios can show the following:
- that each byte becomes the right ranked code word;
- that data changing during the wait is ignored;
- that the interleaved limit holds over every byte value and over every mix of data and filler;
- that a reset in the middle of a word restarts the rhythm cleanly.

// File: rtl/rll89_pkg.sv
package rll89_pkg;

    localparam int DATA_W    = 8;
    localparam int CODE_W    = 9;
    localparam int NUM_SYM   = 1 << DATA_W;
    localparam int NUM_WORDS = 1 << CODE_W;
    localparam int K_MAX     = 4;   // plain zero-run limit
    localparam int I_MAX     = 4;   // interleaved zero-run limit
    localparam int EDGE_MAX  = 2;   // zeros allowed at either end of a word
    localparam int CNT_W     = $clog2(CODE_W);
    localparam int RUN_SAT   = ((K_MAX > I_MAX) ? K_MAX : I_MAX) + 1;
    localparam int RUN_W     = $clog2(RUN_SAT + 1);

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [RUN_W-1:0]  run_t;

    localparam code_t FILL_WORD = '1;

    // Zeros before the first one, walking down from index 'first' by 'step'.
    function automatic int seq_lead(code_t w, int first, int step);
        int  n;
        logic hit;
        n   = 0;
        hit = 1'b0;
        for (int i = first; i >= 0; i -= step) begin
            if (!hit) begin
                if (w[i]) hit = 1'b1;
                else      n++;
            end
        end
        return n;
    endfunction

    // Zeros after the last one on the same walk.
    function automatic int seq_trail(code_t w, int first, int step);
        int n;
        n = 0;
        for (int i = first; i >= 0; i -= step) begin
            if (w[i]) n = 0;
            else      n++;
        end
        return n;
    endfunction

    // Longest zero run on the same walk.
    function automatic int seq_maxrun(code_t w, int first, int step);
        int n;
        int best;
        n    = 0;
        best = 0;
        for (int i = first; i >= 0; i -= step) begin
            if (w[i]) n = 0;
            else      n++;
            if (n > best) best = n;
        end
        return best;
    endfunction

    function automatic logic word_ok(code_t w);
        logic ok;
        ok = (seq_lead(w, CODE_W-1, 1)   <= EDGE_MAX) &&
             (seq_trail(w, CODE_W-1, 1)  <= EDGE_MAX) &&
             (seq_maxrun(w, CODE_W-1, 1) <= K_MAX);
        for (int p = 0; p < 2; p++) begin
            if (seq_lead(w, CODE_W-1-p, 2)   > EDGE_MAX) ok = 1'b0;
            if (seq_trail(w, CODE_W-1-p, 2)  > EDGE_MAX) ok = 1'b0;
            if (seq_maxrun(w, CODE_W-1-p, 2) > I_MAX)    ok = 1'b0;
        end
        return ok;
    endfunction

    // Rank table: entry n holds the n-th smallest legal word.
    function automatic logic [NUM_SYM*CODE_W-1:0] build_code_table();
        logic [NUM_SYM*CODE_W-1:0] t;
        int idx;
        t   = '0;
        idx = 0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (idx < NUM_SYM && word_ok(code_t'(w))) begin
                t[idx*CODE_W +: CODE_W] = code_t'(w);
                idx++;
            end
        end
        return t;
    endfunction

    function automatic run_t run_step(run_t cur, logic bit_in);
        if (bit_in)                     return '0;
        else if (cur == run_t'(RUN_SAT)) return cur;
        else                            return cur + run_t'(1);
    endfunction

endpackage

// File: rtl/rll89_code_rom.sv
module rll89_code_rom
    import rll89_pkg::*;
(
    input  data_t sym,
    output code_t word
);
    localparam logic [NUM_SYM*CODE_W-1:0] CODE_TBL = build_code_table();

    code_t rom [NUM_SYM];

    for (genvar g = 0; g < NUM_SYM; g++) begin : g_rom
        assign rom[g] = CODE_TBL[g*CODE_W +: CODE_W];
    end

    assign word = rom[sym];
endmodule

// File: rtl/rll89_serializer.sv
module rll89_serializer
    import rll89_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t load_word,
    input  logic  load_valid,
    output logic  load_ready,
    output logic  ser_bit,
    output logic  ser_start,
    output logic  ser_under
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CODE_W - 1);

    typedef struct packed {
        code_t            shreg;
        logic [CNT_W-1:0] pos;
        logic             under;
    } ser_state_t;

    ser_state_t ser_d, ser_q;

    always_comb begin
        ser_d      = ser_q;
        load_ready = (ser_q.pos == LAST_POS);
        if (load_ready) begin
            ser_d.pos   = '0;
            ser_d.shreg = load_valid ? load_word : FILL_WORD;
            ser_d.under = ~load_valid;
        end else begin
            ser_d.pos   = ser_q.pos + CNT_W'(1);
            ser_d.shreg = {ser_q.shreg[CODE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q.shreg <= FILL_WORD;
            ser_q.pos   <= '0;
            ser_q.under <= 1'b0;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign ser_bit   = ser_q.shreg[CODE_W-1];
    assign ser_start = (ser_q.pos == '0);
    assign ser_under = ser_q.under;
endmodule

// File: rtl/rll89_run_monitor.sv
module rll89_run_monitor
    import rll89_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic viol
);
    typedef struct packed {
        run_t       zrun;
        run_t [1:0] irun;
        logic       phase;
        logic       err;
    } mon_state_t;

    mon_state_t mon_d, mon_q;

    always_comb begin
        mon_d       = mon_q;
        mon_d.zrun  = run_step(mon_q.zrun, bit_in);
        mon_d.phase = ~mon_q.phase;
        for (int p = 0; p < 2; p++) begin
            if (mon_q.phase == p[0])
                mon_d.irun[p] = run_step(mon_q.irun[p], bit_in);
        end
        mon_d.err = (mon_d.zrun    > run_t'(K_MAX)) ||
                    (mon_d.irun[0] > run_t'(I_MAX)) ||
                    (mon_d.irun[1] > run_t'(I_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) mon_q <= '0;
        else     mon_q <= mon_d;
    end

    assign viol = mon_q.err;
endmodule

// File: rtl/rll89_encoder.sv
module rll89_encoder
    import rll89_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic       code_bit,
    output logic       word_start,
    output logic       underrun,
    output logic       run_err
);
    code_t mapped;

    rll89_code_rom u_rom (
        .sym  (in_data),
        .word (mapped)
    );

    rll89_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .load_word  (mapped),
        .load_valid (in_valid),
        .load_ready (in_ready),
        .ser_bit    (code_bit),
        .ser_start  (word_start),
        .ser_under  (underrun)
    );

    rll89_run_monitor u_mon (
        .clk    (clk),
        .rst    (rst),
        .bit_in (code_bit),
        .viol   (run_err)
    );
endmodule

// File: rtl/rll89_encoder_chk.sv
module rll89_encoder_chk
    import rll89_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic code_bit,
    input logic word_start,
    input logic underrun,
    input logic run_err
);
    logic [CNT_W-1:0] pos_q;
    run_t             zrun_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            zrun_q <= '0;
        end else begin
            pos_q  <= (pos_q == CNT_W'(CODE_W - 1)) ? '0 : pos_q + CNT_W'(1);
            zrun_q <= run_step(zrun_q, code_bit);
        end
    end

    assert_start_phase_R3: assert property (@(posedge clk) disable iff (rst)
        word_start == (pos_q == '0));

    assert_ready_then_start_R4: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> word_start);

    assert_fill_on_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> underrun);

    assert_data_not_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid) |=> !underrun);

    assert_under_steady_R5: assert property (@(posedge clk) disable iff (rst)
        !word_start |-> $stable(underrun));

    assert_zero_run_R6: assert property (@(posedge clk) disable iff (rst)
        zrun_q <= run_t'(K_MAX));

    assert_no_violation_R8: assert property (@(posedge clk) disable iff (rst)
        !run_err);
endmodule

bind rll89_encoder rll89_encoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .code_bit   (code_bit),
    .word_start (word_start),
    .underrun   (underrun),
    .run_err    (run_err)
);

// File: tb/rll89_encoder_test.sv
`timescale 1ns/1ps
module rll89_encoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready, code_bit, word_start, underrun, run_err;

    int checks = 0;
    int fails  = 0;

    logic [8:0] exp_tbl [256];
    logic [8:0] expq [$];

    always #2.5 clk = ~clk;

    rll89_encoder uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .code_bit(code_bit), .word_start(word_start),
        .underrun(underrun), .run_err(run_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Bench view of a legal word: bits listed first-sent first.
    function automatic bit legal(input logic [8:0] w);
        bit b [9];
        for (int k = 0; k < 9; k++) b[k] = w[8-k];
        for (int s = 1; s <= 2; s++) begin
            for (int off = 0; off < s; off++) begin
                int lead, run, worst, last;
                bit seen;
                lead = 0; run = 0; worst = 0; seen = 0;
                for (int k = off; k < 9; k += s) begin
                    if (b[k]) begin seen = 1; run = 0; end
                    else begin
                        run++;
                        if (!seen) lead++;
                    end
                    if (run > worst) worst = run;
                end
                last = run;
                if (lead > 2 || last > 2 || worst > 4) return 0;
            end
        end
        return 1;
    endfunction

    // Monitor: reassembles words and compares with the scoreboard.
    int         bidx;
    longint     tpos;
    int         gz;
    int         iz [2];
    logic [8:0] acc, cur_exp, nxt_exp;
    bit         cur_under, nxt_under;

    always @(negedge clk) begin
        if (rst) begin
            bidx = 0; tpos = 0; gz = 0; iz[0] = 0; iz[1] = 0;
            nxt_exp = 9'h1FF; nxt_under = 0; acc = '0;
        end else begin
            if (bidx == 0) begin
                cur_exp = nxt_exp; cur_under = nxt_under; acc = '0;
            end
            chk(word_start == (bidx == 0), "R3", "word_start", int'(word_start), int'(bidx == 0));
            chk(underrun == cur_under, "R5", "underrun", int'(underrun), int'(cur_under));
            chk(in_ready == (bidx == 8), "R4", "in_ready", int'(in_ready), int'(bidx == 8));
            chk(!run_err, "R8", "run_err", int'(run_err), 0);
            acc = {acc[7:0], code_bit};
            gz = code_bit ? 0 : gz + 1;
            iz[tpos % 2] = code_bit ? 0 : iz[tpos % 2] + 1;
            chk(gz <= 4, "R6", "zero run", gz, 4);
            chk(iz[tpos % 2] <= 4, "R7", "interleaved zero run", iz[tpos % 2], 4);
            if (in_ready) begin
                if (in_valid) begin
                    if (expq.size() == 0) begin
                        chk(0, "R4", "unexpected accept", 1, 0);
                        nxt_exp = 'x; nxt_under = 0;
                    end else begin
                        nxt_exp = expq.pop_front(); nxt_under = 0;
                    end
                end else begin
                    nxt_exp = 9'h1FF; nxt_under = 1;
                end
            end
            if (bidx == 8) begin
                if (cur_under) chk(acc == cur_exp, "R5", "filler word", int'(acc), int'(cur_exp));
                else           chk(acc == cur_exp, "R2", "code word", int'(acc), int'(cur_exp));
            end
            bidx = (bidx == 8) ? 0 : bidx + 1;
            tpos++;
        end
    end

    // Driver: pushes the expected word, then holds the byte until taken.
    task automatic send(input logic [7:0] b);
        expq.push_back(exp_tbl[b]);
        in_data  = b;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // R9: data scrambled while waiting; only the ready-cycle value counts.
    task automatic send_noisy(input logic [7:0] b);
        expq.push_back(exp_tbl[b]);
        in_valid = 1'b1;
        in_data  = 8'($urandom);
        forever begin
            @(negedge clk);
            if (in_ready) break;
            #1 in_data = 8'($urandom);
        end
        #1 in_data = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_data = 8'($urandom);
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk(code_bit == 1'b1,  "R1", {tag, " code_bit"},   int'(code_bit), 1);
        chk(word_start == 1'b1,"R1", {tag, " word_start"}, int'(word_start), 1);
        chk(in_ready == 1'b0,  "R1", {tag, " in_ready"},   int'(in_ready), 0);
        chk(underrun == 1'b0,  "R1", {tag, " underrun"},   int'(underrun), 0);
        chk(run_err == 1'b0,   "R1", {tag, " run_err"},    int'(run_err), 0);
    endtask

    initial begin
        automatic int n = 0;
        for (int w = 0; w < 512 && n < 256; w++) begin
            if (legal(9'(w))) begin exp_tbl[n] = 9'(w); n++; end
        end
        chk(n == 256, "R2", "legal word count", n, 256);
        chk(exp_tbl[0] == 9'h049, "R2", "byte 0 word", int'(exp_tbl[0]), 9'h049);

        repeat (4) @(posedge clk);
        @(negedge clk);
        check_reset_state("in reset");
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check_reset_state("after release");

        idle(25);                                      // R5 filler words
        send(8'h00); send(8'hFF); send(8'h55); send(8'hAA);
        for (int b = 0; b < 256; b++) send(8'(b));     // R2, R6, R7 full sweep
        for (int b = 255; b >= 0; b -= 3) begin        // gaps mix fill and data
            send(8'(b));
            idle(b % 14);
        end
        for (int i = 0; i < 12; i++) send_noisy(8'($urandom));   // R9
        idle(20);

        // R1: reset part-way through a word
        do @(negedge clk); while (!word_start);
        repeat (3) @(negedge clk);
        @(posedge clk); #1 rst = 1'b1;
        expq.delete();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_reset_state("mid-word reset");
        @(posedge clk); #1 rst = 1'b0;
        send(8'h3C); send(8'hC3); idle(3); send(8'h01);
        idle(30);
        chk(expq.size() == 0, "R4", "all bytes taken", expq.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule